// File: doc/BRIEF.md
# Mailbox Channel Request Router

This block sits between a host-facing mailbox and a set of child devices, each reached through its own channel. The host writes 32-bit words into an outbound window. The low nibble of each word selects the target channel. If that child is free, the word goes to it directly. If it is busy, the word waits in an outbound queue until the child at the head of the queue becomes free.

In the other direction, each child raises an available flag while it holds a response. Every cycle the router fetches one response word from the lowest-numbered child whose flag is set, and pushes that word into an inbound mailbox. It stops fetching while the inbound mailbox reports full. Deliveries to the children share one data bus, with a one-hot strobe to select the child. Fetches use a one-hot strobe, and the child returns its word in the same cycle.

Top module: `mbox_router`

## Requirements
- R1: A host write is accepted only when address bits [7:4] equal 4'hA and bits [1:0] equal 0, so offsets 0xA0, 0xA4, 0xA8 and 0xAC act the same. Writes to any other address have no effect.
- R2: The target channel is bits [3:0] of the written word. A word whose channel value is NCH or more is discarded.
- R3: An accepted word whose target is not busy appears one cycle after the write. It is shown as a single-cycle strobe on `chan_deliver[ch]`, with the whole word on `chan_deliver_data`.
- R4: An accepted word whose target is busy enters the outbound queue. Any write that arrives while the queue holds DEPTH words is discarded, whatever its target.
- R5: The queue is served in arrival order, from its head only. When the head's target is not busy, the head is popped and delivered one cycle later. A direct host delivery in the same cycle takes the bus first, and the head then waits for a later cycle.
- R6: At most one `chan_deliver` bit is high in any cycle.
- R7: While `inb_full` is low, exactly one fetch is made per cycle, from the lowest-numbered channel whose `chan_avail` is set. `inb_push` is high in that cycle, and `inb_data` carries that child's word.
- R8: While `inb_full` is high, no fetch strobe and no push occur.
- R9: Reset empties the outbound queue and clears any pending delivery. While reset is high, available flags are treated as clear, so no fetch or push occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_valid | input | 1 | Host write strobe |
| host_wr_addr | input | AW | Host write byte offset |
| host_wr_data | input | 32 | Host write word |
| chan_busy | input | NCH | Per-child busy flag (a request is still pending) |
| chan_avail | input | NCH | Per-child response-available flag |
| chan_fetch_data | input | NCH*32 | Response words, with channel i in bits [i*32 +: 32] |
| inb_full | input | 1 | Inbound mailbox has no room |
| chan_deliver | output | NCH | One-hot delivery strobe |
| chan_deliver_data | output | 32 | Word being delivered |
| chan_fetch | output | NCH | One-hot fetch strobe |
| inb_push | output | 1 | Push strobe into the inbound mailbox |
| inb_data | output | 32 | Word pushed inbound |

## Verification
Writes are applied at the accepted offsets, at neighbouring offsets and with out-of-range channel values. This separates the address decode from the channel check. Bursts aimed at one busy child fill the queue and then overrun it, and a write to an idle child while the queue is full shows that the full check comes before routing. A busy release that coincides with a direct write exposes the bus arbitration. Releasing a child that is not at the head shows that the queue does not reorder. On the response side, several available flags are held together while `inb_full` is toggled and the flags are dropped one by one. This exercises the ascending priority and the stall, and a cycle-by-cycle model of the queue and the scan is compared against the outputs.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam int DW     = 32;
    localparam int CH_W   = 4;
    localparam logic [3:0] WIN_TAG = 4'hA;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
        logic [DW-1:0]   word;
    } wr_req_t;

    typedef enum logic [1:0] {
        DLV_NONE   = 2'd0,
        DLV_DIRECT = 2'd1,
        DLV_DRAIN  = 2'd2
    } dlv_src_e;

    function automatic logic in_window(input logic [7:0] a);
        return (a[7:4] == WIN_TAG) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [CH_W-1:0] chan_of(input logic [DW-1:0] w);
        return w[CH_W-1:0];
    endfunction

endpackage

// File: rtl/mbr_fifo.sv
module mbr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/mbr_collect.sv
module mbr_collect #(
    parameter int NCH = 9,
    parameter int DW  = 32,
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              rst,
    input  logic [NCH-1:0]    chan_avail,
    input  logic [NCH*DW-1:0] chan_fetch_data,
    input  logic              inb_full,
    output logic [NCH-1:0]    chan_fetch,
    output logic              inb_push,
    output logic [DW-1:0]     inb_data
);
    logic [SW-1:0] sel;
    logic          any;
    logic          go;

    // Scan from the top down so the lowest set channel is kept last.
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_avail[i]) begin
                sel = SW'(i);
                any = 1'b1;
            end
        end
    end

    assign go         = any && !inb_full && !rst;
    assign chan_fetch = go ? (NCH'(1) << sel) : '0;
    assign inb_push   = go;
    assign inb_data   = chan_fetch_data[sel*DW +: DW];
endmodule

// File: rtl/mbox_router.sv
module mbox_router
    import mbr_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_valid,
    input  logic [AW-1:0]     host_wr_addr,
    input  logic [DW-1:0]     host_wr_data,
    input  logic [NCH-1:0]    chan_busy,
    input  logic [NCH-1:0]    chan_avail,
    input  logic [NCH*DW-1:0] chan_fetch_data,
    input  logic              inb_full,
    output logic [NCH-1:0]    chan_deliver,
    output logic [DW-1:0]     chan_deliver_data,
    output logic [NCH-1:0]    chan_fetch,
    output logic              inb_push,
    output logic [DW-1:0]     inb_data
);
    wr_req_t          req;
    logic [15:0]      busy_ext;
    logic             ch_ok, accept, tgt_busy;
    logic             q_push, q_pop, q_empty, q_full;
    logic [DW-1:0]    q_head;
    logic [CW-1:0]    q_count;
    logic [CH_W-1:0]  head_ch;
    dlv_src_e         src;

    assign busy_ext = 16'(chan_busy);

    always_comb begin
        req.hit  = host_wr_valid && in_window(host_wr_addr[7:0]);
        req.ch   = chan_of(host_wr_data);
        req.word = host_wr_data;
    end

    assign ch_ok    = (32'(req.ch) < NCH);
    assign tgt_busy = busy_ext[req.ch];
    assign accept   = req.hit && !q_full && ch_ok;
    assign q_push   = accept && tgt_busy;
    assign head_ch  = chan_of(q_head);

    always_comb begin
        src = DLV_NONE;
        if (accept && !tgt_busy)                src = DLV_DIRECT;
        else if (!q_empty && !busy_ext[head_ch]) src = DLV_DRAIN;
    end

    assign q_pop = (src == DLV_DRAIN);

    mbr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_outq (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .pop   (q_pop),
        .wdata (req.word),
        .head  (q_head),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_deliver      <= '0;
            chan_deliver_data <= '0;
        end else begin
            case (src)
                DLV_DIRECT: begin
                    chan_deliver      <= NCH'(1) << req.ch;
                    chan_deliver_data <= req.word;
                end
                DLV_DRAIN: begin
                    chan_deliver      <= NCH'(1) << head_ch;
                    chan_deliver_data <= q_head;
                end
                default: chan_deliver <= '0;
            endcase
        end
    end

    mbr_collect #(.NCH(NCH), .DW(DW)) u_collect (
        .rst             (rst),
        .chan_avail      (chan_avail),
        .chan_fetch_data (chan_fetch_data),
        .inb_full        (inb_full),
        .chan_fetch      (chan_fetch),
        .inb_push        (inb_push),
        .inb_data        (inb_data)
    );
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int NCH   = 9,
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           host_wr_valid,
    input logic [AW-1:0]  host_wr_addr,
    input logic [31:0]    host_wr_data,
    input logic [NCH-1:0] chan_busy,
    input logic [NCH-1:0] chan_avail,
    input logic           inb_full,
    input logic [NCH-1:0] chan_deliver,
    input logic [31:0]    chan_deliver_data,
    input logic [NCH-1:0] chan_fetch,
    input logic           inb_push,
    input logic [CW-1:0]  fill
);
    logic [15:0] busy_w;
    logic [3:0]  wch;
    logic        direct_req;

    assign busy_w     = 16'(chan_busy);
    assign wch        = host_wr_data[3:0];
    assign direct_req = host_wr_valid && (host_wr_addr[7:4] == 4'hA) &&
                        (host_wr_addr[1:0] == 2'b00) && (fill < CW'(DEPTH)) &&
                        (32'(wch) < NCH) && !busy_w[wch];

    p_direct_r3: assert property (@(posedge clk) disable iff (rst)
        direct_req |=> (chan_deliver == (NCH'(1) << $past(wch))) &&
                       (chan_deliver_data == $past(host_wr_data)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    p_one_deliver_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_deliver));

    p_fetch_avail_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_fetch) && ((chan_fetch & ~chan_avail) == '0));

    p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
        inb_full |-> (!inb_push && (chan_fetch == '0)));

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (chan_deliver == '0) && (fill == '0));
endmodule

bind mbox_router mbr_checker #(.NCH(NCH), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .host_wr_valid     (host_wr_valid),
    .host_wr_addr      (host_wr_addr),
    .host_wr_data      (host_wr_data),
    .chan_busy         (chan_busy),
    .chan_avail        (chan_avail),
    .inb_full          (inb_full),
    .chan_deliver      (chan_deliver),
    .chan_deliver_data (chan_deliver_data),
    .chan_fetch        (chan_fetch),
    .inb_push          (inb_push),
    .fill              (q_count)
);

// File: tb/mbox_router_bench.sv
`timescale 1ns/1ps
module mbox_router_bench;
    localparam int NCH = 9;
    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr_valid = 1'b0;
    logic [7:0]        host_wr_addr = '0;
    logic [31:0]       host_wr_data = '0;
    logic [NCH-1:0]    chan_busy = '0;
    logic [NCH-1:0]    chan_avail = '0;
    logic [NCH*32-1:0] chan_fetch_data;
    logic              inb_full = 1'b0;
    logic [NCH-1:0]    chan_deliver;
    logic [31:0]       chan_deliver_data;
    logic [NCH-1:0]    chan_fetch;
    logic              inb_push;
    logic [31:0]       inb_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R9";
    int fcnt [NCH];

    logic [31:0]    mq [$];
    logic [NCH-1:0] exp_dv = '0;
    logic [31:0]    exp_dd = '0;

    always #2.5 clk = ~clk;

    mbox_router #(.NCH(NCH), .DEPTH(DEPTH), .AW(8)) u_mbox_router (
        .clk(clk), .rst(rst), .host_wr_valid(host_wr_valid),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .chan_busy(chan_busy), .chan_avail(chan_avail),
        .chan_fetch_data(chan_fetch_data), .inb_full(inb_full),
        .chan_deliver(chan_deliver), .chan_deliver_data(chan_deliver_data),
        .chan_fetch(chan_fetch), .inb_push(inb_push), .inb_data(inb_data)
    );

    // Child response words: channel number and a per-channel fetch count.
    for (genvar g = 0; g < NCH; g++) begin : g_child
        assign chan_fetch_data[g*32 +: 32] = {16'hF00D, 8'(g), 8'(fcnt[g])};
    end

    // Reference model of the outbound path, updated on every edge.
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) if (chan_fetch[i]) fcnt[i] = fcnt[i] + 1;
        if (rst) begin
            mq.delete();
            exp_dv = '0;
        end else begin
            bit direct, enq, drain;
            int sz0, ch;
            logic [31:0] hd;
            direct = 0; enq = 0; drain = 0;
            sz0 = mq.size();
            ch = int'(host_wr_data[3:0]);
            exp_dv = '0;
            if (host_wr_valid && host_wr_addr[7:4] == 4'hA && host_wr_addr[1:0] == 2'b00
                && sz0 < DEPTH && ch < NCH) begin
                if (chan_busy[ch]) enq = 1;
                else begin
                    direct = 1;
                    exp_dv = NCH'(1) << ch;
                    exp_dd = host_wr_data;
                end
            end
            if (!direct && sz0 > 0) begin
                hd = mq[0];
                if (!chan_busy[int'(hd[3:0])]) begin
                    drain = 1;
                    exp_dv = NCH'(1) << int'(hd[3:0]);
                    exp_dd = hd;
                    void'(mq.pop_front());
                end
            end
            if (enq) mq.push_back(host_wr_data);
        end
    end

    function automatic logic [NCH-1:0] exp_fetch();
        if (rst || inb_full) return '0;
        for (int i = 0; i < NCH; i++) if (chan_avail[i]) return NCH'(1) << i;
        return '0;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called just after a falling edge with the inputs for the coming edge set.
    task automatic cyc();
        logic [NCH-1:0] ef;
        #0.5;
        ef = exp_fetch();
        chk(chan_fetch == ef, "fetch", 64'(chan_fetch), 64'(ef));
        chk(inb_push == (ef != '0), "push", 64'(inb_push), 64'(ef != '0));
        if (ef != '0) begin
            logic [31:0] ed;
            ed = 32'hF00D0000;
            for (int i = 0; i < NCH; i++) if (ef[i]) ed = {16'hF00D, 8'(i), 8'(fcnt[i])};
            chk(inb_data == ed, "inb_data", 64'(inb_data), 64'(ed));
        end
        @(posedge clk);
        @(negedge clk);
        chk(chan_deliver == exp_dv, "deliver", 64'(chan_deliver), 64'(exp_dv));
        chk($countones(chan_deliver) <= 1, "deliver onehot R6", 64'(chan_deliver), 64'(0));
        if (exp_dv != '0)
            chk(chan_deliver_data == exp_dd, "deliver_data", 64'(chan_deliver_data), 64'(exp_dd));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        host_wr_valid = 1'b1;
        host_wr_addr = a;
        host_wr_data = d;
        cyc();
        host_wr_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) fcnt[i] = 0;
        @(negedge clk);
        tag = "R9";
        chan_avail = 9'h024;
        idle(3);
        chan_avail = '0;
        rst = 1'b0;
        idle(1);
        chk(chan_deliver == '0 && !inb_push, "reset state R9", 64'(chan_deliver), 64'(0));

        tag = "R1";
        wr(8'h90, 32'h1234_5671);
        wr(8'hA2, 32'h1234_5671);
        wr(8'hB0, 32'h1234_5671);
        wr(8'hA0, 32'hA0A0_0001);
        wr(8'hA4, 32'hA4A4_0002);
        wr(8'hA8, 32'hA8A8_0003);
        wr(8'hAC, 32'hACAC_0000);
        idle(1);

        tag = "R2";
        wr(8'hA0, 32'h0000_0009);
        wr(8'hA0, 32'h0000_000F);
        wr(8'hA0, 32'h5555_0008);
        idle(1);

        tag = "R4";
        chan_busy = 9'h008;
        for (int k = 0; k < 5; k++) wr(8'hA4, 32'h3000_0003 | (32'(k) << 8));
        wr(8'hA0, 32'h7777_0000);
        idle(1);
        tag = "R5";
        chan_busy = '0;
        idle(5);

        chan_busy = 9'h004;
        wr(8'hA0, 32'hAAAA_0002);
        chan_busy = '0;
        wr(8'hA0, 32'hBBBB_0004);
        idle(2);

        chan_busy = 9'h00C;
        wr(8'hA0, 32'hCCCC_0002);
        wr(8'hA0, 32'hDDDD_0003);
        chan_busy = 9'h004;
        idle(3);
        chan_busy = '0;
        idle(3);

        tag = "R7";
        chan_avail = 9'h0A4;
        idle(3);
        tag = "R8";
        inb_full = 1'b1;
        idle(2);
        tag = "R7";
        inb_full = 1'b0;
        chan_avail = 9'h0A0;
        idle(2);
        chan_avail = 9'h080;
        wr(8'hA8, 32'hEEEE_0006);
        chan_avail = '0;
        idle(1);

        tag = "R9";
        chan_busy = 9'h008;
        wr(8'hA0, 32'h9999_0003);
        wr(8'hA0, 32'h9998_0003);
        rst = 1'b1;
        chan_avail = 9'h010;
        idle(2);
        chan_avail = '0;
        chan_busy = '0;
        rst = 1'b0;
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule